// File: doc/BRIEF.md
# Quad-Lane Serial Peripheral Master

This block is a serial peripheral master with a single shift engine. It can move data over one, two or four data lines. Software controls it through a small register bus. A write to the transmit register starts a word. While that word is still shifting, a second write can be parked in a holding register, so words follow one another without a pause in the serial clock. Each received word lands in a receive buffer. Status flags report an empty transmit holding register, a full receive buffer and an overrun, and a single interrupt line combines them.

In one-line mode every word is full duplex. In two-line and four-line mode the software picks the direction. For a receive, the master releases all data lines and only supplies the clock. The value written to the transmit register is then only a trigger. The slave-select line is a plain software-controlled output. It is held across as many words as software wants.

Top module: `quad_spi_master`

## Requirements
- R1: After reset the serial clock is low, slave select is high, no data line is enabled, the interrupt is low, RXD reads 0 and FLAGS reads 0x1 (only transmit-empty set).
- R2: With lane mode 0 (MODE bits 1:0 = 0), a TXD write (address 0) starts a full-duplex word. N = MODE bits 7:4 plus 1 low bits of TXD go out on line 0, most significant bit first. Line 1 is sampled at the same time, and RXD (address 1) returns the received bits in its low N bits, with zeros above them.
- R3: Each word gives exactly MODE bits 7:4 plus 1 clock pulses. The clock idles low between transfers, and the busy flag (FLAGS bit 3) reads 0 once the engine is idle.
- R4: With lane mode 1 (two lines) or 2 (four lines) and the receive bit set (CTRL bit 1 = 1), no data line is ever enabled. Each clock shifts in 2 or 4 bits, with the highest-numbered line as the most significant bit, and RXD holds the newest bits right-aligned.
- R5: With lane mode 2 and the receive bit clear, the four lines are enabled during the word. The top four bits of the aligned TXD word are driven each clock, with line 3 carrying the most significant of them.
- R6: When a word completes, the receive-full flag (FLAGS bit 1) sets. Reading RXD with the read strobe clears it.
- R7: If a word completes while receive-full is still set, RXD is overwritten with the new word and the overrun flag (FLAGS bit 2) sets.
- R8: Writing FLAGS (address 4) clears each of receive-full and overrun whose bit is written as 1, and leaves the other unchanged.
- R9: A TXD write while a word is shifting clears transmit-empty (FLAGS bit 0) until the engine loads that word. The next word then begins on the falling edge that ends the current one, so the clock period stays uniform across the boundary.
- R10: The interrupt output is high exactly when any flag among transmit-empty, receive-full and overrun is set with its enable bit set (IEN, address 5, bits 0, 1 and 2).
- R11: The slave select output (active low) follows the inverse of CTRL bit 0 (address 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops RXD) |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational on address |
| sclk_o | output | 1 | Serial clock |
| ss_no | output | 1 | Slave select, active low |
| sd_i | input | 4 | Data line inputs |
| sd_o | output | 4 | Data line outputs |
| sd_oe_o | output | 4 | Data line output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong bit counter or a wrong lane-mode latch shows at the serial pins within one word. The clock pulse count, the serial bit order or the data-line enables come out wrong during that same transfer. Damaged flag state shows at the next FLAGS read or on the interrupt line within one clock cycle. A broken holding-register handoff shows as a stretched low clock phase at the word boundary, or as a lost second word. Both show before the second word ends.

// File: rtl/qsm_pkg.sv
package qsm_pkg;

  typedef enum logic [1:0] {
    LANE_X1  = 2'd0,
    LANE_X2  = 2'd1,
    LANE_X4  = 2'd2,
    LANE_RSV = 2'd3
  } lane_mode_e;

  localparam logic [2:0] ADDR_TXD   = 3'd0;
  localparam logic [2:0] ADDR_RXD   = 3'd1;
  localparam logic [2:0] ADDR_CTRL  = 3'd2;
  localparam logic [2:0] ADDR_MODE  = 3'd3;
  localparam logic [2:0] ADDR_FLAGS = 3'd4;
  localparam logic [2:0] ADDR_IEN   = 3'd5;

  localparam int FLG_TXE  = 0;
  localparam int FLG_RXF  = 1;
  localparam int FLG_OVR  = 2;
  localparam int FLG_BUSY = 3;

  function automatic int lane_count(lane_mode_e m);
    case (m)
      LANE_X2: return 2;
      LANE_X4: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic lane_mode_e norm_mode(lane_mode_e m);
    return (m == LANE_RSV) ? LANE_X1 : m;
  endfunction

endpackage

// File: rtl/qsm_clkgen.sv
module qsm_clkgen #(
  parameter int HALF_DIV = 2,
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/qsm_engine.sv
module qsm_engine import qsm_pkg::*; #(
  parameter int DATA_W = 16,
  localparam int LEN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tx_pend_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  lane_mode_e        mode_i,
  input  logic              dir_rx_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [3:0]        sd_i,
  output logic              load_ack_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              word_done_o,
  output logic              rx_only_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic [3:0]        sd_o,
  output logic [3:0]        sd_oe_o
);

  logic              busy_q, sclk_q, rx_only_q;
  logic [LEN_W-1:0]  bit_cnt_q, len_q;
  lane_mode_e        mode_q;
  logic [DATA_W-1:0] tx_sr_q, rx_sr_q, tx_next, rx_next;
  logic              last_fall;

  function automatic logic [DATA_W-1:0] align_tx(logic [DATA_W-1:0] d,
                                                 logic [LEN_W-1:0] l,
                                                 lane_mode_e m);
    int nbits;
    nbits = (int'(l) + 1) * lane_count(norm_mode(m));
    if (nbits >= DATA_W) return d;
    return d << (DATA_W - nbits);
  endfunction

  assign last_fall   = busy_q && tick_i && sclk_q && (bit_cnt_q == len_q);
  assign word_done_o = last_fall;
  assign load_ack_o  = tx_pend_i && (!busy_q || last_fall);
  assign busy_o      = busy_q;
  assign sclk_o      = sclk_q;
  assign rx_only_o   = rx_only_q;
  assign rx_word_o   = rx_sr_q;

  always_comb begin
    case (mode_q)
      LANE_X2: begin
        rx_next = {rx_sr_q[DATA_W-3:0], sd_i[1:0]};
        tx_next = {tx_sr_q[DATA_W-3:0], 2'b00};
      end
      LANE_X4: begin
        rx_next = {rx_sr_q[DATA_W-5:0], sd_i};
        tx_next = {tx_sr_q[DATA_W-5:0], 4'b0000};
      end
      default: begin
        rx_next = {rx_sr_q[DATA_W-2:0], sd_i[1]};
        tx_next = {tx_sr_q[DATA_W-2:0], 1'b0};
      end
    endcase
  end

  // Per-lane drive: lane i carries the bit (lanes-1-i) below the MSB.
  for (genvar i = 0; i < 4; i++) begin : g_lane
    always_comb begin
      int lanes;
      lanes = lane_count(mode_q);
      sd_o[i]    = 1'b0;
      sd_oe_o[i] = 1'b0;
      if (i < lanes) begin
        sd_o[i]    = tx_sr_q[DATA_W - lanes + i];
        sd_oe_o[i] = busy_q && !rx_only_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      sclk_q    <= 1'b0;
      rx_only_q <= 1'b0;
      bit_cnt_q <= '0;
      len_q     <= '0;
      mode_q    <= LANE_X1;
      tx_sr_q   <= '0;
      rx_sr_q   <= '0;
    end else if (load_ack_o) begin
      busy_q    <= 1'b1;
      sclk_q    <= 1'b0;
      bit_cnt_q <= '0;
      len_q     <= len_i;
      mode_q    <= norm_mode(mode_i);
      rx_only_q <= dir_rx_i && (norm_mode(mode_i) != LANE_X1);
      tx_sr_q   <= align_tx(tx_data_i, len_i, mode_i);
      rx_sr_q   <= '0;
    end else if (busy_q && tick_i) begin
      if (!sclk_q) begin
        sclk_q  <= 1'b1;
        rx_sr_q <= rx_next;
      end else begin
        sclk_q <= 1'b0;
        if (bit_cnt_q == len_q) begin
          busy_q <= 1'b0;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
          tx_sr_q   <= tx_next;
        end
      end
    end
  end

endmodule

// File: rtl/qsm_regs.sv
module qsm_regs import qsm_pkg::*; #(
  parameter int DATA_W = 16,
  localparam int LEN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              load_ack_i,
  input  logic              word_done_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              busy_i,
  output logic              tx_pend_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              ss_on_o,
  output logic              dir_rx_o,
  output lane_mode_e        mode_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              rx_full_o,
  output logic              ovr_o,
  output logic [2:0]        ien_o,
  output logic              irq_o
);

  logic              tx_pend_q, rx_full_q, ovr_q, ss_on_q, dir_rx_q;
  logic [DATA_W-1:0] tx_data_q, rx_buf_q;
  lane_mode_e        mode_q;
  logic [LEN_W-1:0]  len_q;
  logic [2:0]        ien_q;
  logic              wr_txd, wr_flags, rd_rxd;

  assign wr_txd   = reg_wr_i && (reg_addr_i == ADDR_TXD);
  assign wr_flags = reg_wr_i && (reg_addr_i == ADDR_FLAGS);
  assign rd_rxd   = reg_rd_i && (reg_addr_i == ADDR_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_pend_q <= 1'b0;
      tx_data_q <= '0;
      rx_buf_q  <= '0;
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
      ss_on_q   <= 1'b0;
      dir_rx_q  <= 1'b0;
      mode_q    <= LANE_X1;
      len_q     <= '0;
      ien_q     <= '0;
    end else begin
      // a new write wins over the engine taking the old word
      if (wr_txd) begin
        tx_pend_q <= 1'b1;
        tx_data_q <= reg_wdata_i;
      end else if (load_ack_i) begin
        tx_pend_q <= 1'b0;
      end

      if (word_done_i) rx_buf_q <= rx_word_i;

      if (word_done_i)                                rx_full_q <= 1'b1;
      else if (rd_rxd || (wr_flags && reg_wdata_i[FLG_RXF])) rx_full_q <= 1'b0;

      if (word_done_i && rx_full_q)                   ovr_q <= 1'b1;
      else if (wr_flags && reg_wdata_i[FLG_OVR])      ovr_q <= 1'b0;

      if (reg_wr_i && reg_addr_i == ADDR_CTRL) begin
        ss_on_q  <= reg_wdata_i[0];
        dir_rx_q <= reg_wdata_i[1];
      end
      if (reg_wr_i && reg_addr_i == ADDR_MODE) begin
        mode_q <= lane_mode_e'(reg_wdata_i[1:0]);
        len_q  <= reg_wdata_i[7:4];
      end
      if (reg_wr_i && reg_addr_i == ADDR_IEN) ien_q <= reg_wdata_i[2:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_TXD:   reg_rdata_o = tx_data_q;
      ADDR_RXD:   reg_rdata_o = rx_buf_q;
      ADDR_CTRL:  reg_rdata_o[1:0] = {dir_rx_q, ss_on_q};
      ADDR_MODE:  begin
        reg_rdata_o[7:4] = len_q;
        reg_rdata_o[1:0] = mode_q;
      end
      ADDR_FLAGS: reg_rdata_o[3:0] = {busy_i, ovr_q, rx_full_q, !tx_pend_q};
      ADDR_IEN:   reg_rdata_o[2:0] = ien_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign tx_pend_o = tx_pend_q;
  assign tx_data_o = tx_data_q;
  assign ss_on_o   = ss_on_q;
  assign dir_rx_o  = dir_rx_q;
  assign mode_o    = mode_q;
  assign len_o     = len_q;
  assign rx_full_o = rx_full_q;
  assign ovr_o     = ovr_q;
  assign ien_o     = ien_q;
  assign irq_o     = |(ien_q & {ovr_q, rx_full_q, !tx_pend_q});

endmodule

// File: rtl/quad_spi_master.sv
module quad_spi_master import qsm_pkg::*; #(
  parameter int DATA_W   = 16,
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sclk_o,
  output logic              ss_no,
  input  logic [3:0]        sd_i,
  output logic [3:0]        sd_o,
  output logic [3:0]        sd_oe_o,
  output logic              irq_o
);

  logic              tick, busy, load_ack, word_done, rx_only;
  logic              tx_pend, ss_on, dir_rx, rx_full, ovr;
  logic [DATA_W-1:0] tx_data, rx_word;
  logic [3:0]        len;
  logic [2:0]        ien;
  lane_mode_e        mode;

  qsm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_wr_i, .reg_rd_i, .reg_wdata_i, .reg_rdata_o,
    .load_ack_i (load_ack),
    .word_done_i(word_done),
    .rx_word_i  (rx_word),
    .busy_i     (busy),
    .tx_pend_o  (tx_pend),
    .tx_data_o  (tx_data),
    .ss_on_o    (ss_on),
    .dir_rx_o   (dir_rx),
    .mode_o     (mode),
    .len_o      (len),
    .rx_full_o  (rx_full),
    .ovr_o      (ovr),
    .ien_o      (ien),
    .irq_o      (irq_o)
  );

  qsm_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk_i, .rst_ni,
    .run_i (busy),
    .tick_o(tick)
  );

  qsm_engine #(.DATA_W(DATA_W)) u_engine (
    .clk_i, .rst_ni,
    .tick_i     (tick),
    .tx_pend_i  (tx_pend),
    .tx_data_i  (tx_data),
    .mode_i     (mode),
    .dir_rx_i   (dir_rx),
    .len_i      (len),
    .sd_i       (sd_i),
    .load_ack_o (load_ack),
    .busy_o     (busy),
    .sclk_o     (sclk_o),
    .word_done_o(word_done),
    .rx_only_o  (rx_only),
    .rx_word_o  (rx_word),
    .sd_o       (sd_o),
    .sd_oe_o    (sd_oe_o)
  );

  assign ss_no = !ss_on;

endmodule

// File: rtl/qsm_checker.sv
module qsm_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sclk_i,
  input logic       busy_i,
  input logic       rx_only_i,
  input logic       word_done_i,
  input logic       rx_full_i,
  input logic       ovr_i,
  input logic [2:0] ien_i,
  input logic [3:0] sd_oe_i,
  input logic       irq_i
);

  // R3
  sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sclk_i);

  // R4
  rx_lines_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_only_i |-> (sd_oe_i == 4'b0000));

  // R6
  rx_full_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_i |=> rx_full_i);

  // R7
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done_i && rx_full_i) |=> ovr_i);

  // R10
  irq_rx_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_i && ien_i[1]) |-> irq_i);

  // R10
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == 3'b000) |-> !irq_i);

endmodule

bind quad_spi_master qsm_checker u_qsm_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sclk_i     (sclk_o),
  .busy_i     (busy),
  .rx_only_i  (rx_only),
  .word_done_i(word_done),
  .rx_full_i  (rx_full),
  .ovr_i      (ovr),
  .ien_i      (ien),
  .sd_oe_i    (sd_oe_o),
  .irq_i      (irq_o)
);

// File: tb/tb_quad_spi_master.sv
`timescale 1ns/1ps
module tb_quad_spi_master;
  localparam int DW = 16;
  localparam int HD = 2;
  localparam int CLK_NS = 20;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [2:0]    addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0, rdata;
  logic          sclk, ss_n, irq;
  logic [3:0]    sd_in, sd_out, sd_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] slave_sr = '0;
  int          sl_lanes = 1;
  logic [31:0] mosi_cap = '0, quad_cap = '0;
  logic [3:0]  oe_seen = '0;
  int          pulses = 0;
  time         first_rise = 0, last_rise = 0;

  always #(CLK_NS/2) clk = ~clk;

  quad_spi_master #(.DATA_W(DW), .HALF_DIV(HD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sclk_o(sclk), .ss_no(ss_n),
    .sd_i(sd_in), .sd_o(sd_out), .sd_oe_o(sd_oe), .irq_o(irq)
  );

  // slave model: changes data on falling clock, master samples on rising
  always_comb begin
    case (sl_lanes)
      2:       sd_in = {2'b00, slave_sr[31:30]};
      4:       sd_in = slave_sr[31:28];
      default: sd_in = {2'b00, slave_sr[31], 1'b0};
    endcase
  end
  always @(negedge sclk) slave_sr = slave_sr << sl_lanes;
  always @(posedge sclk) begin
    if (pulses == 0) first_rise = $time;
    last_rise = $time;
    pulses    = pulses + 1;
    mosi_cap  = {mosi_cap[30:0], sd_out[0]};
    quad_cap  = {quad_cap[27:0], sd_out};
    oe_seen   = oe_seen | sd_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, input bit pop, output logic [DW-1:0] d);
    @(negedge clk); addr = a; rd = pop; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [DW-1:0] f;
    for (int i = 0; i < 5000; i++) begin
      reg_read(3'd4, 1'b0, f);
      if (f[3] == 1'b0 && f[0] == 1'b1) return;
    end
    check("R3 idle timeout", 32'd1, 32'd0);
  endtask

  task automatic arm(input logic [31:0] sl, input int lanes);
    slave_sr = sl; sl_lanes = lanes;
    mosi_cap = '0; quad_cap = '0; oe_seen = '0; pulses = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 sclk", sclk, 0);
    check("R1 ss_n", ss_n, 1);
    check("R1 oe", sd_oe, 0);
    check("R1 irq", irq, 0);
    reg_read(3'd4, 1'b0, d); check("R1 flags", d, 16'h0001);
    reg_read(3'd1, 1'b0, d); check("R1 rxd", d, 16'h0000);
  endtask

  task automatic t_slave_select();
    reg_write(3'd2, 16'h0001); #1 check("R11 asserted", ss_n, 0);
    reg_write(3'd2, 16'h0000); #1 check("R11 released", ss_n, 1);
    reg_write(3'd2, 16'h0001);
  endtask

  task automatic t_single(input logic [3:0] len, input logic [15:0] txd,
                          input logic [15:0] rx_pat, input logic [15:0] exp_mosi);
    logic [DW-1:0] d;
    int n = int'(len) + 1;
    reg_write(3'd3, {8'h00, len, 4'h0});
    arm({rx_pat, 16'h0} << (16 - n), 1);
    reg_write(3'd0, txd);
    wait_idle();
    check("R3 pulse count", pulses, n);
    check("R3 sclk idle", sclk, 0);
    check("R2 mosi bits", mosi_cap & ((32'd1 << n) - 1), exp_mosi);
    reg_read(3'd4, 1'b0, d); check("R6 rx full set", d[1], 1);
    reg_read(3'd1, 1'b1, d); check("R2 rx word", d, rx_pat & 16'((32'd1 << n) - 1));
    reg_read(3'd4, 1'b0, d); check("R6 rx full cleared by read", d[1], 0);
  endtask

  task automatic t_multi_rx(input logic [1:0] mode, input logic [3:0] len,
                            input logic [15:0] exp_rx);
    logic [DW-1:0] d;
    int lanes = (mode == 2'd2) ? 4 : 2;
    int nb = (int'(len) + 1) * lanes;
    reg_write(3'd2, 16'h0003);
    reg_write(3'd3, {8'h00, len, 2'b00, mode});
    arm({exp_rx, 16'h0} << (16 - nb), lanes);
    reg_write(3'd0, 16'hFFFF);
    wait_idle();
    check("R4 lines never driven", oe_seen, 4'h0);
    check("R4 pulse count", pulses, int'(len) + 1);
    reg_read(3'd1, 1'b1, d); check("R4 rx word", d, exp_rx);
    reg_write(3'd2, 16'h0001);
  endtask

  task automatic t_quad_tx();
    reg_write(3'd2, 16'h0001);
    reg_write(3'd3, 16'h0032);
    arm(32'h0, 4);
    reg_write(3'd0, 16'h5A3C);
    wait_idle();
    check("R5 quad tx nibbles", quad_cap[15:0], 16'h5A3C);
    check("R5 all lanes enabled", oe_seen, 4'hF);
    check("R3 pulse count quad", pulses, 4);
    begin logic [DW-1:0] d; reg_read(3'd1, 1'b1, d); end
  endtask

  task automatic t_back_to_back();
    logic [DW-1:0] d;
    reg_write(3'd3, 16'h0070);
    arm(32'hF00F_0000, 1);
    reg_write(3'd0, 16'h0081);
    reg_write(3'd0, 16'h007E);
    reg_read(3'd4, 1'b0, d); check("R9 tx empty low while queued, busy", d & 16'h9, 16'h8);
    wait_idle();
    check("R9 pulses two words", pulses, 16);
    check("R9 mosi two words", mosi_cap[15:0], 16'h817E);
    check("R9 uniform clock", 32'(last_rise - first_rise), 32'(15 * 2 * HD * CLK_NS));
    reg_read(3'd4, 1'b0, d); check("R7 overrun and full", d[2:1], 2'b11);
    reg_read(3'd1, 1'b0, d); check("R7 newest word kept", d, 16'h000F);
  endtask

  task automatic t_flag_clear();
    logic [DW-1:0] d;
    reg_write(3'd4, 16'h0004);
    reg_read(3'd4, 1'b0, d); check("R8 overrun cleared only", d[2:1], 2'b01);
    reg_write(3'd4, 16'h0002);
    reg_read(3'd4, 1'b0, d); check("R8 rx full cleared", d[2:1], 2'b00);
  endtask

  task automatic t_irq();
    logic [DW-1:0] d;
    reg_write(3'd5, 16'h0001); #1 check("R10 tx empty irq", irq, 1);
    reg_write(3'd5, 16'h0002); #1 check("R10 rx full irq masked low", irq, 0);
    reg_write(3'd3, 16'h0030);
    arm(32'h0, 1);
    reg_write(3'd0, 16'h0003);
    wait_idle();
    #1 check("R10 rx full irq", irq, 1);
    reg_read(3'd1, 1'b1, d);
    #1 check("R10 irq drops after read", irq, 0);
    reg_write(3'd5, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slave_select();
    t_single(4'd7,  16'h00A5, 16'h003C, 16'h00A5);
    t_single(4'd15, 16'h1234, 16'hBEEF, 16'h1234);
    t_single(4'd3,  16'h000B, 16'h0009, 16'h000B);
    t_multi_rx(2'd2, 4'd3, 16'hC0DE);
    t_multi_rx(2'd1, 4'd5, 16'h0ABC);
    t_quad_tx();
    t_back_to_back();
    t_flag_clear();
    t_irq();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule